// File: doc/BRIEF.md
# Page-Offset-Indexed, Physically-Tagged L1 Lookup

This block is the lookup datapath of a direct-mapped level-one data cache. The set is chosen only from address bits that lie inside the page offset. Those bits are the same in the virtual and the physical address, so the array read begins in the same cycle as the translation lookup and needs no translated bits. Each line carries the physical page number it was filled from. The hit decision is made one cycle later, once both the stored tag and the translation result are available.

A request presents a virtual address. One cycle later the translation model supplies its hit flag and page number. The registered response appears one cycle after that. A separate fill port writes a whole line, its physical page number and its valid bit at the set named by the physical address. Lines are 16 bytes, there are 256 sets and pages are 4 KiB. An elaboration check refuses any parameter set where the set index and line offset would reach above the page offset. Under that limit, two virtual aliases of one physical address always land in the same set.

Top module: `vipt_cache`

## Requirements
- R1: While reset is high and on the cycle after it falls, `rsp_valid` is 0. After reset every set is invalid, so a lookup at any set misses whatever page number the translation returns.
- R2: A request sampled at clock edge N (`req_valid` high) produces exactly one response with `rsp_valid` high after edge N+2. No response appears without a request, and requests may be issued on consecutive cycles.
- R3: A lookup hits (`rsp_hit` = 1) only when the selected line is valid, its stored page number equals `tlb_ppn`, and `tlb_hit` is 1. Both translation inputs are sampled at edge N+1.
- R4: On a hit, `rsp_data` is 32-bit word `req_vaddr[3:2]` of the line. Word 0 is line bits 31:0 and word 3 is bits 127:96. On a miss, `rsp_data` is 0.
- R5: The set is `req_vaddr[11:4]` and bits 31:12 of `req_vaddr` have no effect. Two virtual addresses with different upper bits but the same low 12 bits, translated to the same page, return the same hit and data.
- R6: A fill sampled at an edge writes `fill_line`, stores `fill_paddr[31:12]` as the tag and sets the valid bit of set `fill_paddr[11:4]`.
- R7: When `tlb_hit` is 0, the response is a miss with data 0, even if the stored tag equals `tlb_ppn`.
- R8: A lookup sampled at the same edge as a fill to the same set sees the set's previous contents. A lookup sampled one edge later sees the new line.
- R9: A fill replaces whatever the set held before. A lookup with the old page number then misses, and one with the new page number hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address of the lookup |
| tlb_hit | input | 1 | Translation found, one cycle after the request |
| tlb_ppn | input | 20 | Translated page number, one cycle after the request |
| fill_valid | input | 1 | Write a line this cycle |
| fill_paddr | input | 32 | Physical address of the line being written |
| fill_line | input | 128 | Line contents, word 0 in the low bits |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_data | output | 32 | Selected word on a hit, zero on a miss |

## Verification
The hardest case to reach from the ports is a lookup and a fill that hit the same set on the same clock edge. There the answer depends on whether the arrays return old or new contents. The stimulus drives a fill and a request to one set in a single cycle, then repeats the request on the next cycle, so both sides of the ordering are observed. Aliasing is reached by filling a line once and reading it back through virtual addresses whose upper bits differ, while the translation returns the same page number. A matching tag with a failed translation separates the translation flag from the tag compare.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned BYTE_BITS = 8;

  // true when set index and line offset stay inside the page offset
  function automatic bit index_in_page(input int unsigned idx_w,
                                       input int unsigned off_w,
                                       input int unsigned page_w);
    return (idx_w + off_w) <= page_w;
  endfunction

  typedef enum logic [1:0] {
    LK_IDLE = 2'b00,
    LK_MISS = 2'b01,
    LK_HIT  = 2'b10
  } lookup_kind_e;
endpackage

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  // tag RAM: read-before-write, no reset, so block RAM is inferred
  always_ff @(posedge clk) begin
    rd_tag <= tag_mem[rd_idx];
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  // valid bits kept in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= valid_q[rd_idx];
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end

  assert_fill_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LINE_W = 128
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [LINE_W-1:0] line_mem [DEPTH];

  // read-before-write, single clock, no reset
  always_ff @(posedge clk) begin
    rd_line <= line_mem[rd_idx];
    if (wr_en) line_mem[wr_idx] <= wr_line;
  end
endmodule

// File: rtl/vipt_compare.sv
module vipt_compare
  import vipt_pkg::*;
#(
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned LINE_W = 128,
  parameter int unsigned WORD_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              lk_valid,
  input  logic [$clog2(LINE_W/WORD_W)-1:0]  lk_word,
  input  logic                              line_valid,
  input  logic [TAG_W-1:0]                  line_tag,
  input  logic [LINE_W-1:0]                 line_data,
  input  logic                              tlb_hit,
  input  logic [TAG_W-1:0]                  tlb_ppn,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [WORD_W-1:0]                 rsp_data
);
  localparam int unsigned WORDS = LINE_W / WORD_W;

  logic [WORD_W-1:0] words [WORDS];
  logic [WORD_W-1:0] sel_word;
  lookup_kind_e      kind;

  // split the line into words
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = line_data[w*WORD_W +: WORD_W];
  end

  assign sel_word = words[lk_word];

  always_comb begin
    if (!lk_valid)
      kind = LK_IDLE;
    else if (line_valid && tlb_hit && (line_tag == tlb_ppn))
      kind = LK_HIT;
    else
      kind = LK_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (kind != LK_IDLE);
      rsp_hit   <= (kind == LK_HIT);
      rsp_data  <= (kind == LK_HIT) ? sel_word : '0;
    end
  end

  assert_hit_needs_tlb_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> $past(tlb_hit));
  assert_hit_needs_tag_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> ($past(line_valid) && $past(line_tag) == $past(tlb_ppn)));
  assert_hit_is_response_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  assert_miss_zero_data_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int unsigned PA_W       = 32,
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PAGE_OFF_W = 12,
  parameter int unsigned LINE_OFF_W = 4,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned WORD_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic [VA_W-1:0]                   req_vaddr,
  input  logic                              tlb_hit,
  input  logic [PA_W-PAGE_OFF_W-1:0]        tlb_ppn,
  input  logic                              fill_valid,
  input  logic [PA_W-1:0]                   fill_paddr,
  input  logic [(BYTE_BITS<<LINE_OFF_W)-1:0] fill_line,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [WORD_W-1:0]                 rsp_data
);
  localparam int unsigned PPN_W   = PA_W - PAGE_OFF_W;
  localparam int unsigned LINE_W  = BYTE_BITS << LINE_OFF_W;
  localparam int unsigned WORDS   = LINE_W / WORD_W;
  localparam int unsigned WSEL_W  = $clog2(WORDS);
  localparam int unsigned BSEL_W  = $clog2(WORD_W / BYTE_BITS);

  // the index must come from untranslated bits only
  if (!index_in_page(IDX_W, LINE_OFF_W, PAGE_OFF_W)) begin : g_bad_geometry
    $error("set index plus line offset exceeds page offset");
  end

  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [PPN_W-1:0]  wr_tag;
  logic [WSEL_W-1:0] word_now;
  logic              lk_valid_q;
  logic [WSEL_W-1:0] lk_word_q;
  logic              line_valid;
  logic [PPN_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;

  logic unused_va_bits;
  logic unused_pa_bits;
  assign unused_va_bits = ^{req_vaddr[VA_W-1:PAGE_OFF_W], req_vaddr[BSEL_W-1:0]};
  assign unused_pa_bits = ^fill_paddr[LINE_OFF_W-1:0];

  assign rd_idx   = req_vaddr[LINE_OFF_W +: IDX_W];
  assign word_now = req_vaddr[BSEL_W +: WSEL_W];
  assign wr_idx   = fill_paddr[LINE_OFF_W +: IDX_W];
  assign wr_tag   = fill_paddr[PA_W-1:PAGE_OFF_W];

  // stage 1: array read in flight, translation arriving
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid_q <= 1'b0;
      lk_word_q  <= '0;
    end else begin
      lk_valid_q <= req_valid;
      lk_word_q  <= word_now;
    end
  end

  vipt_tag_array #(.IDX_W(IDX_W), .TAG_W(PPN_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .wr_en    (fill_valid),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag)
  );

  vipt_data_array #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_idx  (rd_idx),
    .rd_line (line_data),
    .wr_en   (fill_valid),
    .wr_idx  (wr_idx),
    .wr_line (fill_line)
  );

  vipt_compare #(.TAG_W(PPN_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid_q),
    .lk_word    (lk_word_q),
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .line_data  (line_data),
    .tlb_hit    (tlb_hit),
    .tlb_ppn    (tlb_ppn),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_data   (rsp_data)
  );

  assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2));
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);
endmodule

// File: tb/test_vipt_cache.sv
module test_vipt_cache;
  localparam int CLK_PERIOD = 10;
  localparam int SETS       = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [31:0]  req_vaddr = '0;
  logic         tlb_hit = 1'b0;
  logic [19:0]  tlb_ppn = '0;
  logic         fill_valid = 1'b0;
  logic [31:0]  fill_paddr = '0;
  logic [127:0] fill_line = '0;
  logic         rsp_valid;
  logic         rsp_hit;
  logic [31:0]  rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_cache i_vipt_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .fill_valid(fill_valid),
    .fill_paddr(fill_paddr), .fill_line(fill_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit           m_valid [SETS];
  logic [19:0]  m_tag   [SETS];
  logic [127:0] m_line  [SETS];
  bit           s1_v;
  bit           s1_lv;
  logic [19:0]  s1_tag;
  logic [127:0] s1_line;
  int           s1_word;
  string        s1_lbl;
  bit           e_v;
  bit           e_hit;
  logic [31:0]  e_data;
  string        e_lbl;
  string        req_lbl = "";
  bit           p_th = 0;
  logic [19:0]  p_pp = '0;

  always @(posedge clk) begin
    if (rst) begin
      s1_v = 0; e_v = 0; e_hit = 0; e_data = '0;
      for (int i = 0; i < SETS; i++) m_valid[i] = 0;
    end else begin
      e_v   = s1_v;
      e_hit = s1_v && s1_lv && tlb_hit && (s1_tag == tlb_ppn);
      e_data = e_hit ? s1_line[s1_word*32 +: 32] : 32'h0;
      e_lbl = s1_lbl;
      s1_v = req_valid;
      if (req_valid) begin
        s1_lv   = m_valid[req_vaddr[11:4]];
        s1_tag  = m_tag[req_vaddr[11:4]];
        s1_line = m_line[req_vaddr[11:4]];
        s1_word = int'(req_vaddr[3:2]);
        s1_lbl  = req_lbl;
      end
      if (fill_valid) begin
        m_valid[fill_paddr[11:4]] = 1;
        m_tag[fill_paddr[11:4]]   = fill_paddr[31:12];
        m_line[fill_paddr[11:4]]  = fill_line;
      end
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        checks++;
        if (rsp_valid !== 1'b0) begin
          fails++;
          $display("FAIL R1 rsp_valid during reset: got %b expected 0", rsp_valid);
        end
      end else begin
        checks++;
        if (rsp_valid !== e_v) begin
          fails++;
          $display("FAIL R2 rsp_valid: got %b expected %b", rsp_valid, e_v);
        end
        if (e_v) begin
          checks++;
          if (rsp_hit !== e_hit || rsp_data !== e_data) begin
            fails++;
            $display("FAIL %s hit/data: got %b/%h expected %b/%h",
                     e_lbl, rsp_hit, rsp_data, e_hit, e_data);
          end
        end
      end
    end
  end

  function automatic logic [127:0] mk_line(input logic [31:0] s);
    return {s ^ 32'h3333_0003, s ^ 32'h2222_0002, s ^ 32'h1111_0001, s};
  endfunction

  task automatic cyc(input bit rq, input logic [31:0] va, input bit th,
                     input logic [19:0] pp, input string lbl,
                     input bit fv, input logic [31:0] pa, input logic [127:0] ln);
    @(negedge clk);
    req_valid  = rq;
    req_vaddr  = va;
    tlb_hit    = p_th;
    tlb_ppn    = p_pp;
    p_th       = th;
    p_pp       = pp;
    req_lbl    = lbl;
    fill_valid = fv;
    fill_paddr = pa;
    fill_line  = ln;
  endtask

  task automatic look(input logic [31:0] va, input bit th, input logic [19:0] pp,
                      input string lbl);
    cyc(1, va, th, pp, lbl, 0, '0, '0);
  endtask

  task automatic fill(input logic [31:0] pa, input logic [127:0] ln);
    cyc(0, '0, 0, '0, "", 1, pa, ln);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, "", 0, '0, '0);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: every set starts invalid
    look(32'h0000_0000, 1, 20'h00000, "R1");
    look(32'h7777_0550, 1, 20'h00000, "R1");
    look(32'hFFFF_FFFC, 1, 20'hFFFFF, "R1");
    idle(3);
    // R6: fills at a few sets
    fill(32'h1234_5000, mk_line(32'hA000_0000));
    fill(32'h0ABC_D5A0, mk_line(32'hB000_0000));
    fill(32'hFFFF_FFF0, mk_line(32'hC000_0000));
    idle(1);
    // R3/R4: hits on every word, back-to-back (R2)
    look(32'h0000_0000, 1, 20'h12345, "R4");
    look(32'h0000_0004, 1, 20'h12345, "R4");
    look(32'h0000_0008, 1, 20'h12345, "R4");
    look(32'h0000_000C, 1, 20'h12345, "R4");
    look(32'h0000_0FF4, 1, 20'hFFFFF, "R6");
    idle(3);
    // R3: wrong page number misses
    look(32'h0000_0000, 1, 20'h12346, "R3");
    look(32'h0000_05A8, 1, 20'h0ABCC, "R3");
    // R7: translation failed though tag matches
    look(32'h0000_05A8, 0, 20'h0ABCD, "R7");
    idle(3);
    // R5: aliases with different upper bits, same page
    look(32'h1234_55A8, 1, 20'h0ABCD, "R5");
    look(32'hFEDC_B5A8, 1, 20'h0ABCD, "R5");
    look(32'h0000_15AC, 1, 20'h0ABCD, "R5");
    idle(3);
    // R8: lookup and fill to set 0x33 on the same edge, then again
    fill(32'h5555_5330, mk_line(32'hD000_0000));
    idle(1);
    cyc(1, 32'h0000_0334, 1, 20'h55555, "R8", 1, 32'h6666_6330, mk_line(32'hE000_0000));
    look(32'h0000_0334, 1, 20'h66666, "R8");
    look(32'h0000_0334, 1, 20'h55555, "R9");
    idle(3);
    // R9: overwrite of set 0x00 drops the old page
    fill(32'h0001_1000, mk_line(32'hF000_0000));
    look(32'h0000_0008, 1, 20'h12345, "R9");
    look(32'h0000_0008, 1, 20'h00011, "R9");
    idle(3);
    // sweep: fill a spread of sets then read them back
    for (int i = 0; i < SETS; i += 17)
      fill({12'h0A0 + 12'(i), i[7:0], 4'h0}, mk_line(32'(i * 32'h0101_0101)));
    for (int i = 0; i < SETS; i += 17)
      look({20'h3_0000 + 20'(i), i[7:0], 2'(i), 2'b00}, 1, 20'(12'h0A0 + 12'(i)), "R6");
    idle(4);
    report();
  end
endmodule